// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the per-line horizontal timing for an interline-transfer CCD sensor. A pixel counter advances on a pixel-rate strobe derived from the master clock. The strobe fires on one master clock in two or one in four, depending on the clock plan. The counter wraps at a line length that depends on the selected sensor format and TV system. From the count the block decodes a line sync pulse, a horizontal blanking window, a clamp window over the dummy pixels, and a clamp window over the back optical-black pixels. It also produces the two-phase horizontal register clocks with their transfer-enable window.

Four formats are selected through a 2-bit mode input. A new mode is taken only when the current line ends, so a line is never cut short. Every output is registered and changes in the same clock cycle as the pixel count it belongs to.

Top module: `ccd_hline_tg`

## Requirements
- R1: While reset is held, and after release until the first cycle with `pix_en` high, `pix_cnt` is 0 and `hd`, `hblank`, `clamp_dummy`, `clamp_ob`, `hxfer_en`, `h1` and `h2` are all 0. The first strobe presents count 0 with its decoded outputs. The same holds after a reset applied in the middle of a line.
- R2: `pix_cnt` and every pulse output change only on a clock edge where `pix_en` is high.
- R3: The mode code sets the line length: 0 gives 606 counts, 1 gives 606, 2 gives 910 and 3 gives 908. On the strobe after count length−1, the count returns to 0.
- R4: `hd` is high for counts 0 to 19 of every line. It always lies inside the blanking window.
- R5: `hblank` is high for counts 0 to B−1. B is 53 for modes 0 and 1, 77 for mode 2 and 91 for mode 3.
- R6: `clamp_dummy` is high for counts B to B+D−1, directly after blanking. D is 16 for modes 0 and 1 and 22 for modes 2 and 3.
- R7: `clamp_ob` is high for the last K counts of the line. K is 25 for mode 0, 30 for mode 1 and 40 for modes 2 and 3.
- R8: Inside blanking, `h1`=1, `h2`=0 and `hxfer_en`=0. Outside blanking, `hxfer_en`=1 and `h1` toggles on every strobe with `h2` its complement. At the first count after blanking, `h1` is 0.
- R9: A change of `mode` in the middle of a line has no effect until the line wraps. The current line keeps its old length and windows, and the new mode governs from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate strobe, one master clock wide |
| mode | input | 2 | Format select: 0 510H NTSC, 1 510H PAL, 2 760H NTSC, 3 760H PAL |
| pix_cnt | output | 10 | Current horizontal pixel count |
| hd | output | 1 | Line sync pulse |
| hblank | output | 1 | Horizontal blanking window |
| clamp_dummy | output | 1 | Dummy-pixel clamp window |
| clamp_ob | output | 1 | Back optical-black clamp window |
| hxfer_en | output | 1 | Horizontal register transfer enable |
| h1 | output | 1 | Horizontal transfer clock phase 1 |
| h2 | output | 1 | Horizontal transfer clock phase 2 |

## Verification
The assertions assume that `pix_en` is a single-cycle strobe sampled on the master clock. They also assume that `mode` is free to change at any time, because the block itself defers a new mode to the line wrap. The window-ordering checks further assume the default format constants, where the sync pulse fits inside blanking and the dummy region ends before the optical-black region starts. The stimulus raises `pix_en` for one cycle in every three and keeps the default parameters. It moves `mode` both at line ends and in the middle of a line, so the deferral is exercised without going outside those assumptions.

// File: rtl/ccd_htg_pkg.sv
package ccd_htg_pkg;

   // width of the timing constants carried between sub-blocks
   localparam int HTG_TW = 12;

   // window indices used by the decoder and the top level
   localparam int WIN_HD    = 0;
   localparam int WIN_BLANK = 1;
   localparam int WIN_DUMMY = 2;
   localparam int WIN_OB    = 3;
   localparam int HTG_NWIN  = 4;

   typedef enum logic [1:0] {
      HTG_510_NTSC = 2'd0,
      HTG_510_PAL  = 2'd1,
      HTG_760_NTSC = 2'd2,
      HTG_760_PAL  = 2'd3
   } htg_mode_e;

   typedef struct packed {
      logic [HTG_TW-1:0] line_len;
      logic [HTG_TW-1:0] blank_len;
      logic [HTG_TW-1:0] dummy_len;
      logic [HTG_TW-1:0] ob_len;
   } htg_timing_t;

endpackage

// File: rtl/htg_mode_sel.sv
module htg_mode_sel
   import ccd_htg_pkg::*;
#(
   parameter int LINE_510N  = 606,
   parameter int LINE_510P  = 606,
   parameter int LINE_760N  = 910,
   parameter int LINE_760P  = 908,
   parameter int BLANK_510  = 53,
   parameter int BLANK_760N = 77,
   parameter int BLANK_760P = 91,
   parameter int DUMMY_510  = 16,
   parameter int DUMMY_760  = 22,
   parameter int OB_510N    = 25,
   parameter int OB_510P    = 30,
   parameter int OB_760     = 40
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [1:0]  mode_in,
   output htg_timing_t tim_cur,
   output htg_timing_t tim_nxt
);

   htg_mode_e act_q;
   htg_mode_e sel_nxt;

   function automatic htg_timing_t lookup(htg_mode_e m);
      htg_timing_t t;
      case (m)
         HTG_510_NTSC: begin
            t.line_len  = HTG_TW'(LINE_510N);
            t.blank_len = HTG_TW'(BLANK_510);
            t.dummy_len = HTG_TW'(DUMMY_510);
            t.ob_len    = HTG_TW'(OB_510N);
         end
         HTG_510_PAL: begin
            t.line_len  = HTG_TW'(LINE_510P);
            t.blank_len = HTG_TW'(BLANK_510);
            t.dummy_len = HTG_TW'(DUMMY_510);
            t.ob_len    = HTG_TW'(OB_510P);
         end
         HTG_760_NTSC: begin
            t.line_len  = HTG_TW'(LINE_760N);
            t.blank_len = HTG_TW'(BLANK_760N);
            t.dummy_len = HTG_TW'(DUMMY_760);
            t.ob_len    = HTG_TW'(OB_760);
         end
         default: begin
            t.line_len  = HTG_TW'(LINE_760P);
            t.blank_len = HTG_TW'(BLANK_760P);
            t.dummy_len = HTG_TW'(DUMMY_760);
            t.ob_len    = HTG_TW'(OB_760);
         end
      endcase
      return t;
   endfunction

   // a new format is only accepted when the counter reloads
   always_comb sel_nxt = load ? htg_mode_e'(mode_in) : act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_q <= HTG_510_NTSC;
      else if (load) act_q <= sel_nxt;
   end

   always_comb begin
      tim_cur = lookup(act_q);
      tim_nxt = lookup(sel_nxt);
   end

endmodule

// File: rtl/htg_pixel_counter.sv
module htg_pixel_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic [CNT_W-1:0] line_last,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             load
);

   logic running_q;
   logic at_end;

   assign at_end = running_q && (cnt_q == line_last);
   // first strobe after reset and every line end reload the count
   assign load   = pix_en && (!running_q || at_end);

   always_comb begin
      if (!pix_en)   cnt_nxt = cnt_q;
      else if (load) cnt_nxt = '0;
      else           cnt_nxt = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
      end else begin
         cnt_q     <= cnt_nxt;
         running_q <= running_q | pix_en;
      end
   end

endmodule

// File: rtl/htg_range_cmp.sv
module htg_range_cmp
   import ccd_htg_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [HTG_TW-1:0] lo,
   input  logic [HTG_TW-1:0] hi,
   output logic              hit
);

   logic [HTG_TW-1:0] c_ext;

   assign c_ext = HTG_TW'(cnt);
   assign hit   = (c_ext >= lo) && (c_ext < hi);

endmodule

// File: rtl/htg_window_decode.sv
module htg_window_decode
   import ccd_htg_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int HD_WIDTH = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  logic [CNT_W-1:0]    cnt_nxt,
   input  htg_timing_t         tim_nxt,
   output logic [HTG_NWIN-1:0] win_nxt,
   output logic [HTG_NWIN-1:0] win_q
);

   logic [HTG_TW-1:0] lo [HTG_NWIN];
   logic [HTG_TW-1:0] hi [HTG_NWIN];

   always_comb begin
      lo[WIN_HD]    = '0;
      hi[WIN_HD]    = HTG_TW'(HD_WIDTH);
      lo[WIN_BLANK] = '0;
      hi[WIN_BLANK] = tim_nxt.blank_len;
      lo[WIN_DUMMY] = tim_nxt.blank_len;
      hi[WIN_DUMMY] = tim_nxt.blank_len + tim_nxt.dummy_len;
      lo[WIN_OB]    = tim_nxt.line_len - tim_nxt.ob_len;
      hi[WIN_OB]    = tim_nxt.line_len;
   end

   for (genvar gi = 0; gi < HTG_NWIN; gi++) begin : g_win
      htg_range_cmp #(.CNT_W(CNT_W)) u_cmp (
         .cnt (cnt_nxt),
         .lo  (lo[gi]),
         .hi  (hi[gi]),
         .hit (win_nxt[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    win_q <= '0;
      else if (step) win_q <= win_nxt;
   end

endmodule

// File: rtl/htg_hclock_gen.sv
module htg_hclock_gen #(
   parameter logic H1_BLANK_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic blank_nxt,
   output logic h1_q,
   output logic h2_q,
   output logic xfer_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1_q   <= 1'b0;
         h2_q   <= 1'b0;
         xfer_q <= 1'b0;
      end else if (step) begin
         xfer_q <= !blank_nxt;
         if (blank_nxt) begin
            h1_q <= H1_BLANK_LVL;
            h2_q <= !H1_BLANK_LVL;
         end else begin
            h1_q <= !h1_q;
            h2_q <= h1_q;
         end
      end
   end

endmodule

// File: rtl/ccd_hline_tg.sv
module ccd_hline_tg
   import ccd_htg_pkg::*;
#(
   parameter int   CNT_W        = 10,
   parameter int   HD_WIDTH     = 20,
   parameter int   LINE_510N    = 606,
   parameter int   LINE_510P    = 606,
   parameter int   LINE_760N    = 910,
   parameter int   LINE_760P    = 908,
   parameter int   BLANK_510    = 53,
   parameter int   BLANK_760N   = 77,
   parameter int   BLANK_760P   = 91,
   parameter int   DUMMY_510    = 16,
   parameter int   DUMMY_760    = 22,
   parameter int   OB_510N      = 25,
   parameter int   OB_510P      = 30,
   parameter int   OB_760       = 40,
   parameter logic H1_BLANK_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic [1:0]       mode,
   output logic [CNT_W-1:0] pix_cnt,
   output logic             hd,
   output logic             hblank,
   output logic             clamp_dummy,
   output logic             clamp_ob,
   output logic             hxfer_en,
   output logic             h1,
   output logic             h2
);

   localparam int CNT_MAX   = 1 << CNT_W;
   localparam int MIN_BLANK = (BLANK_760N < BLANK_510) ? BLANK_760N : BLANK_510;

   // elaboration-time parameter checks
   if (CNT_W > HTG_TW) begin : g_chk_tw
      $error("CNT_W exceeds timing constant width");
   end
   if (LINE_510N > CNT_MAX || LINE_510P > CNT_MAX ||
       LINE_760N > CNT_MAX || LINE_760P > CNT_MAX) begin : g_chk_len
      $error("line length does not fit the pixel counter");
   end
   if (HD_WIDTH > MIN_BLANK || HD_WIDTH > BLANK_760P) begin : g_chk_hd
      $error("sync pulse longer than blanking");
   end
   if (BLANK_510 + DUMMY_510 > LINE_510P - OB_510P ||
       BLANK_760P + DUMMY_760 > LINE_760P - OB_760) begin : g_chk_order
      $error("dummy region overlaps optical-black region");
   end

   htg_timing_t          tim_cur;
   htg_timing_t          tim_nxt;
   logic                 load;
   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     cnt_nxt;
   logic [CNT_W-1:0]     line_last;
   logic [HTG_NWIN-1:0]  win_nxt;
   logic [HTG_NWIN-1:0]  win_q;

   assign line_last = tim_cur.line_len[CNT_W-1:0] - CNT_W'(1);

   htg_mode_sel #(
      .LINE_510N (LINE_510N),  .LINE_510P (LINE_510P),
      .LINE_760N (LINE_760N),  .LINE_760P (LINE_760P),
      .BLANK_510 (BLANK_510),  .BLANK_760N(BLANK_760N),
      .BLANK_760P(BLANK_760P), .DUMMY_510 (DUMMY_510),
      .DUMMY_760 (DUMMY_760),  .OB_510N   (OB_510N),
      .OB_510P   (OB_510P),    .OB_760    (OB_760)
   ) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .mode_in (mode),
      .tim_cur (tim_cur),
      .tim_nxt (tim_nxt)
   );

   htg_pixel_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_en    (pix_en),
      .line_last (line_last),
      .cnt_q     (cnt_q),
      .cnt_nxt   (cnt_nxt),
      .load      (load)
   );

   htg_window_decode #(.CNT_W(CNT_W), .HD_WIDTH(HD_WIDTH)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (pix_en),
      .cnt_nxt (cnt_nxt),
      .tim_nxt (tim_nxt),
      .win_nxt (win_nxt),
      .win_q   (win_q)
   );

   htg_hclock_gen #(.H1_BLANK_LVL(H1_BLANK_LVL)) u_hclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (pix_en),
      .blank_nxt (win_nxt[WIN_BLANK]),
      .h1_q      (h1),
      .h2_q      (h2),
      .xfer_q    (hxfer_en)
   );

   assign pix_cnt     = cnt_q;
   assign hd          = win_q[WIN_HD];
   assign hblank      = win_q[WIN_BLANK];
   assign clamp_dummy = win_q[WIN_DUMMY];
   assign clamp_ob    = win_q[WIN_OB];

endmodule

// File: rtl/ccd_hline_tg_chk.sv
module ccd_hline_tg_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_en,
   input logic [CNT_W-1:0] pix_cnt,
   input logic             hd,
   input logic             hblank,
   input logic             clamp_dummy,
   input logic             clamp_ob,
   input logic             hxfer_en,
   input logic             h1,
   input logic             h2
);

   logic seen_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_en_q <= 1'b0;
      else if (pix_en) seen_en_q <= 1'b1;
   end

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_en_q |-> (pix_cnt == '0) && !hd && !hblank && !clamp_dummy &&
                     !clamp_ob && !hxfer_en && !h1 && !h2);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(pix_cnt) && $stable(hblank) && $stable(h1) && $stable(hd));

   assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && seen_en_q) |=>
         (pix_cnt == $past(pix_cnt) + CNT_W'(1)) || (pix_cnt == '0));

   assert_hd_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hd |-> hblank);

   assert_dummy_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_dummy |-> !hblank && !clamp_ob);

   assert_ob_outside_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_ob |-> !hblank);

   assert_xfer_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seen_en_q |-> (hxfer_en != hblank) && (h1 != h2));

   assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && hxfer_en) |=> (hxfer_en |-> h1 != $past(h1)));

   assert_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hblank |=> (hblank |-> $stable(h1)));

endmodule

bind ccd_hline_tg ccd_hline_tg_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pix_en      (pix_en),
   .pix_cnt     (pix_cnt),
   .hd          (hd),
   .hblank      (hblank),
   .clamp_dummy (clamp_dummy),
   .clamp_ob    (clamp_ob),
   .hxfer_en    (hxfer_en),
   .h1          (h1),
   .h2          (h2)
);

// File: tb/ccd_hline_tg_tb.sv
module ccd_hline_tg_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       pix_en;
   logic [1:0] mode;
   logic [9:0] pix_cnt;
   logic       hd, hblank, clamp_dummy, clamp_ob, hxfer_en, h1, h2;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   ccd_hline_tg u_dut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode(mode),
      .pix_cnt(pix_cnt), .hd(hd), .hblank(hblank), .clamp_dummy(clamp_dummy),
      .clamp_ob(clamp_ob), .hxfer_en(hxfer_en), .h1(h1), .h2(h2)
   );

   // {mode, count, expected hd, hblank, clamp_dummy, clamp_ob, h1}
   localparam int NV = 28;
   localparam logic [16:0] VECS [NV] = '{
      {2'd0, 10'd0,   5'b11001}, {2'd0, 10'd19,  5'b11001},
      {2'd0, 10'd20,  5'b01001}, {2'd0, 10'd52,  5'b01001},
      {2'd0, 10'd53,  5'b00100}, {2'd0, 10'd54,  5'b00101},
      {2'd0, 10'd68,  5'b00101}, {2'd0, 10'd69,  5'b00000},
      {2'd0, 10'd580, 5'b00001}, {2'd0, 10'd581, 5'b00010},
      {2'd0, 10'd605, 5'b00010},
      {2'd1, 10'd575, 5'b00000}, {2'd1, 10'd576, 5'b00011},
      {2'd1, 10'd605, 5'b00010},
      {2'd2, 10'd0,   5'b11001}, {2'd2, 10'd76,  5'b01001},
      {2'd2, 10'd77,  5'b00100}, {2'd2, 10'd98,  5'b00101},
      {2'd2, 10'd99,  5'b00000}, {2'd2, 10'd869, 5'b00000},
      {2'd2, 10'd870, 5'b00011}, {2'd2, 10'd909, 5'b00010},
      {2'd3, 10'd90,  5'b01001}, {2'd3, 10'd91,  5'b00100},
      {2'd3, 10'd112, 5'b00101}, {2'd3, 10'd113, 5'b00000},
      {2'd3, 10'd868, 5'b00011}, {2'd3, 10'd907, 5'b00010}
   };

   function automatic logic [16:0] observed();
      return {pix_cnt, hd, hblank, clamp_dummy, clamp_ob, h1, hxfer_en, h2};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk) pix_en = 1'b1;
      @(negedge clk) pix_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic advance_to(input int tgt);
      int guard = 0;
      while (int'(pix_cnt) != tgt && guard < 2000) begin
         step();
         guard++;
      end
   endtask

   initial begin
      int cur;
      rst_n  = 1'b0;
      pix_en = 1'b0;
      mode   = 2'd0;
      repeat (4) @(negedge clk);
      check("R1 reset state", 32'(observed()), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 idle before first strobe", 32'(observed()), 32'd0);

      step();
      cur = 0;
      for (int i = 0; i < NV; i++) begin
         logic [1:0] vm;
         logic [9:0] vc;
         logic [4:0] ve;
         {vm, vc, ve} = VECS[i];
         if (int'(vm) != cur) begin
            mode = vm;
            cur  = int'(vm);
            step();
            check("R3 wrap to zero at line end", 32'(pix_cnt), 32'd0);
         end
         advance_to(int'(vc));
         check($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", i), 32'(observed()),
               32'({vc, ve, ~ve[3], ~ve[0]}));
      end

      // R2: no strobe, nothing moves (at mode 3, count 907)
      repeat (10) @(negedge clk);
      check("R2 hold without strobe", 32'(observed()), 32'({10'd907, 5'b00010, 1'b1, 1'b1}));

      // R9: mid-line switch to a shorter format is deferred
      step();
      advance_to(500);
      mode = 2'd0;
      advance_to(700);
      check("R9 old length kept", 32'({pix_cnt, clamp_ob}), 32'({10'd700, 1'b0}));
      advance_to(907);
      step();
      check("R9 wrap at old length", 32'(pix_cnt), 32'd0);
      advance_to(53);
      check("R9 new mode windows", 32'({pix_cnt, hblank, clamp_dummy}), 32'({10'd53, 1'b0, 1'b1}));
      advance_to(605);
      step();
      check("R3 wrap at 606 after switch", 32'(pix_cnt), 32'd0);

      // R1: reset in the middle of a line
      advance_to(300);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-line reset", 32'(observed()), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      step();
      check("R1 restart at zero", 32'(observed()), 32'({10'd0, 5'b11001, 1'b0, 1'b0}));

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule